// File: doc/BRIEF.md
# Compute Engine Program Sequencer

This block walks a small signal-processing engine through its program, which is stored in a flash array that a host processor also uses. Each input-multiplexer frame begins with a start strobe. On that strobe the sequencer samples an 8-bit code-location value, which selects a 1 KB flash block. It then resets its program counter to the first word of that block.

From there it requests 16-bit instruction words one at a time through a request/grant port to the flash-share arbiter. Each granted word is handed to the engine on a registered output. The pass stops when a HALT word is seen.

The program region holds at most 4096 words, and the flash byte address is 18 bits wide. The sequencer refuses to fetch past either limit and raises a sticky bound error. An end-of-frame strobe that arrives while a pass is still running raises a sticky overrun flag. A start strobe that arrives mid-pass also raises overrun, and it restarts the pass. Each flag is cleared by its own write-one-to-clear bit.

Top module: `pgm_sequencer`

## Requirements
- R1: After reset `busy_o`, `fetch_req_o`, `instr_valid_o`, `overrun_o` and `bound_err_o` are all low.
- R2: The cycle after `frame_start_i`, `fetch_req_o` is high with `fetch_addr_o` equal to 1024 times the `code_loc_i` value sampled with the strobe; later changes of `code_loc_i` do not affect the running pass.
- R3: `fetch_req_o` and `fetch_addr_o` hold steady until `fetch_gnt_i`. The word on `fetch_data_i` in a grant cycle appears on `instr_o`, with `instr_valid_o` high, one cycle later. Each grant advances the byte address by 2.
- R4: A granted word equal to HALT (default 16'h0000) is still delivered. `busy_o` is low in the cycle it is presented, and no request follows until the next `frame_start_i`.
- R5: `busy_o` is high from the cycle after `frame_start_i` until the pass ends, and `fetch_req_o` is never high while `busy_o` is low.
- R6: `frame_end_i` while `busy_o` is high sets `overrun_o` and the pass continues; `frame_end_i` while idle changes nothing.
- R7: `frame_start_i` while `busy_o` is high sets `overrun_o` and restarts the pass at the base sampled with the new strobe.
- R8: If the word at program index 4095 is granted and is not HALT, the pass stops, `bound_err_o` is set, and no further address is requested.
- R9: If the next word address would exceed the 18-bit byte address space, no request is made, the pass stops and `bound_err_o` is set.
- R10: `flag_clr_i[0]` clears `overrun_o` and `flag_clr_i[1]` clears `bound_err_o`; a set condition in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Multiplexer state-0 start strobe |
| frame_end_i | input | 1 | Multiplexer end-of-frame strobe |
| code_loc_i | input | 8 | Selects the 1 KB flash block holding the program |
| fetch_req_o | output | 1 | Fetch request to the flash-share arbiter |
| fetch_addr_o | output | 18 | Flash byte address of the requested word |
| fetch_gnt_i | input | 1 | Grant; `fetch_data_i` is valid in this cycle |
| fetch_data_i | input | 16 | Instruction word returned by the flash |
| instr_o | output | 16 | Fetched instruction word |
| instr_valid_o | output | 1 | `instr_o` holds a new word |
| busy_o | output | 1 | A pass is running |
| overrun_o | output | 1 | Sticky: the pass did not finish inside its frame |
| bound_err_o | output | 1 | Sticky: the program tried to run past its region |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 overrun, bit 1 bound error |

## Verification
Two functions can land in the same cycle: an overrun event and the software clear of the overrun flag. The bench provokes this by driving `frame_end_i` and `flag_clr_i[0]` together while a pass is busy. It judges the result by requiring `overrun_o` to read 1 in the next cycle.

A second collision is a start strobe that arrives while fetches are stalled. The bench issues one with grants held off and expects a raised overrun flag, plus a request at the newly sampled base. The scoreboard then confirms that only words from the restarted pass reach `instr_o`.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  localparam int unsigned FLAG_N   = 2;
  localparam int unsigned FLAG_OVR = 0;
  localparam int unsigned FLAG_BND = 1;
endpackage

// File: rtl/pgm_addr_gen.sv
module pgm_addr_gen #(
  parameter int unsigned LOC_W   = 8,
  parameter int unsigned PC_W    = 12,
  parameter int unsigned SHIFT   = 9,
  parameter int unsigned WADDR_W = 17,
  parameter int unsigned BSH     = 1
) (
  input  logic [LOC_W-1:0]       base_i,
  input  logic [PC_W-1:0]        pc_i,
  output logic [WADDR_W+BSH-1:0] byte_addr_o,
  output logic                   overflow_o
);
  localparam int unsigned BASE_W = LOC_W + SHIFT;
  localparam int unsigned MAX_W  = (BASE_W > PC_W) ? BASE_W : PC_W;
  localparam int unsigned SUM_W  = ((MAX_W > WADDR_W) ? MAX_W : WADDR_W) + 1;

  logic [SUM_W-1:0] base_ext;
  logic [SUM_W-1:0] pc_ext;
  logic [SUM_W-1:0] sum;

  always_comb begin
    base_ext    = SUM_W'(base_i) << SHIFT;
    pc_ext      = SUM_W'(pc_i);
    sum         = base_ext + pc_ext;
    overflow_o  = |(sum >> WADDR_W);
    byte_addr_o = {sum[WADDR_W-1:0], {BSH{1'b0}}};
  end
endmodule

// File: rtl/pgm_seq_ctrl.sv
module pgm_seq_ctrl
  import pgm_seq_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned LOC_W      = 8,
  parameter int unsigned PC_W       = 12,
  parameter int unsigned PROG_WORDS = 4096,
  parameter logic [WORD_W-1:0] HALT_OP = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic [LOC_W-1:0]  code_loc_i,
  input  logic              addr_bad_i,
  input  logic              gnt_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              req_o,
  output logic [LOC_W-1:0]  base_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              busy_o,
  output logic [WORD_W-1:0] instr_o,
  output logic              instr_valid_o,
  output logic              ovr_evt_o,
  output logic              bnd_evt_o
);
  localparam logic [PC_W-1:0] LAST_PC = PC_W'(PROG_WORDS - 1);

  seq_state_e        state_q;
  logic [PC_W-1:0]   pc_q;
  logic [LOC_W-1:0]  base_q;
  logic [WORD_W-1:0] instr_q;
  logic              valid_q;
  logic              running;
  logic              take;
  logic              is_halt;
  logic              last_word;

  always_comb begin
    running   = (state_q == ST_RUN);
    req_o     = running && !addr_bad_i;
    take      = req_o && gnt_i && !frame_start_i;
    is_halt   = (data_i == HALT_OP);
    last_word = (pc_q == LAST_PC);
    ovr_evt_o = running && (frame_start_i || frame_end_i);
    bnd_evt_o = running && !frame_start_i &&
                (addr_bad_i || (take && !is_halt && last_word));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      base_q  <= '0;
      instr_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (frame_start_i) begin
        // restart wins over any grant in the same cycle
        state_q <= ST_RUN;
        pc_q    <= '0;
        base_q  <= code_loc_i;
      end else if (running) begin
        if (addr_bad_i) begin
          state_q <= ST_IDLE;
        end else if (take) begin
          instr_q <= data_i;
          valid_q <= 1'b1;
          if (is_halt || last_word) state_q <= ST_IDLE;
          else                      pc_q    <= pc_q + 1'b1;
        end
      end
    end
  end

  assign base_o        = base_q;
  assign pc_o          = pc_q;
  assign busy_o        = running;
  assign instr_o       = instr_q;
  assign instr_valid_o = valid_q;
endmodule

// File: rtl/pgm_seq_flags.sv
module pgm_seq_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (set_i[g])  flag_q <= 1'b1;
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/pgm_sequencer.sv
module pgm_sequencer
  import pgm_seq_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned LOC_W       = 8,
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned PROG_WORDS  = 4096,
  parameter int unsigned BLOCK_BYTES = 1024,
  parameter logic [WORD_W-1:0] HALT_OP = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic [LOC_W-1:0]  code_loc_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_gnt_i,
  input  logic [WORD_W-1:0] fetch_data_i,
  output logic [WORD_W-1:0] instr_o,
  output logic              instr_valid_o,
  output logic              busy_o,
  output logic              overrun_o,
  output logic              bound_err_o,
  input  logic [1:0]        flag_clr_i
);
  localparam int unsigned PC_W    = $clog2(PROG_WORDS);
  localparam int unsigned BSH     = $clog2(WORD_W / 8);
  localparam int unsigned WADDR_W = ADDR_W - BSH;
  localparam int unsigned SHIFT   = $clog2(BLOCK_BYTES) - BSH;

  logic [LOC_W-1:0]  base;
  logic [PC_W-1:0]   pc;
  logic              addr_bad;
  logic              ovr_evt;
  logic              bnd_evt;
  logic [FLAG_N-1:0] flag_set;
  logic [FLAG_N-1:0] flag_q;

  pgm_addr_gen #(
    .LOC_W  (LOC_W),
    .PC_W   (PC_W),
    .SHIFT  (SHIFT),
    .WADDR_W(WADDR_W),
    .BSH    (BSH)
  ) u_addr (
    .base_i     (base),
    .pc_i       (pc),
    .byte_addr_o(fetch_addr_o),
    .overflow_o (addr_bad)
  );

  pgm_seq_ctrl #(
    .WORD_W    (WORD_W),
    .LOC_W     (LOC_W),
    .PC_W      (PC_W),
    .PROG_WORDS(PROG_WORDS),
    .HALT_OP   (HALT_OP)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .frame_end_i  (frame_end_i),
    .code_loc_i   (code_loc_i),
    .addr_bad_i   (addr_bad),
    .gnt_i        (fetch_gnt_i),
    .data_i       (fetch_data_i),
    .req_o        (fetch_req_o),
    .base_o       (base),
    .pc_o         (pc),
    .busy_o       (busy_o),
    .instr_o      (instr_o),
    .instr_valid_o(instr_valid_o),
    .ovr_evt_o    (ovr_evt),
    .bnd_evt_o    (bnd_evt)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_OVR] = ovr_evt;
    flag_set[FLAG_BND] = bnd_evt;
  end

  pgm_seq_flags #(.N(FLAG_N)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (flag_set),
    .clr_i (flag_clr_i),
    .flag_o(flag_q)
  );

  assign overrun_o   = flag_q[FLAG_OVR];
  assign bound_err_o = flag_q[FLAG_BND];
endmodule

// File: rtl/pgm_seq_chk.sv
module pgm_seq_chk #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned LOC_W       = 8,
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned BLOCK_BYTES = 1024,
  parameter logic [WORD_W-1:0] HALT_OP = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_start_i,
  input logic              frame_end_i,
  input logic [LOC_W-1:0]  code_loc_i,
  input logic              fetch_req_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              fetch_gnt_i,
  input logic [WORD_W-1:0] instr_o,
  input logic              instr_valid_o,
  input logic              busy_o,
  input logic              overrun_o,
  input logic              bound_err_o,
  input logic [1:0]        flag_clr_i
);
  localparam int unsigned BLK_LG = $clog2(BLOCK_BYTES);

  p_start_base_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> fetch_req_o &&
      (fetch_addr_o == (ADDR_W'($past(code_loc_i)) << BLK_LG)));

  p_hold_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !fetch_gnt_i && !frame_start_i |=> fetch_req_o && $stable(fetch_addr_o));

  p_halt_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && (instr_o == HALT_OP) |-> !busy_o);

  p_req_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> busy_o);

  p_late_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && frame_end_i |=> overrun_o);

  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && frame_start_i |=> overrun_o && busy_o);

  p_bound_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bound_err_o) |-> !busy_o || $past(frame_start_i));

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i[0] && !(busy_o && (frame_end_i || frame_start_i)) |=> !overrun_o);
endmodule

bind pgm_sequencer pgm_seq_chk #(
  .WORD_W     (WORD_W),
  .LOC_W      (LOC_W),
  .ADDR_W     (ADDR_W),
  .BLOCK_BYTES(BLOCK_BYTES),
  .HALT_OP    (HALT_OP)
) u_chk (.*);

// File: tb/pgm_sequencer_tb.sv
module pgm_sequencer_tb_top;
  localparam int unsigned TMO = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        frame_end = 1'b0;
  logic [7:0]  code_loc = '0;
  logic        fetch_req;
  logic [17:0] fetch_addr;
  logic        fetch_gnt;
  logic [15:0] fetch_data;
  logic [15:0] instr;
  logic        instr_valid;
  logic        busy;
  logic        overrun;
  logic        bound_err;
  logic [1:0]  flag_clr = '0;

  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [15:0] exp_q[$];

  // flash model
  logic [16:0] halt_w = '0;
  bit          halt_on = 1'b0;
  bit          gnt_on = 1'b1;
  bit          gnt_slow = 1'b0;
  int          gnt_cnt = 0;
  logic        gnt_ok = 1'b1;
  logic [16:0] cur_w;

  always #4 clk = ~clk;

  assign cur_w      = fetch_addr[17:1];
  assign fetch_gnt  = fetch_req && gnt_on && gnt_ok;
  assign fetch_data = (halt_on && cur_w == halt_w) ? 16'h0000 : {1'b1, cur_w[14:0]};

  always @(negedge clk) begin
    gnt_cnt <= (gnt_cnt == 2) ? 0 : gnt_cnt + 1;
    gnt_ok  <= !gnt_slow || (gnt_cnt == 2);
  end

  pgm_sequencer dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frame_start_i(frame_start),
    .frame_end_i  (frame_end),
    .code_loc_i   (code_loc),
    .fetch_req_o  (fetch_req),
    .fetch_addr_o (fetch_addr),
    .fetch_gnt_i  (fetch_gnt),
    .fetch_data_i (fetch_data),
    .instr_o      (instr),
    .instr_valid_o(instr_valid),
    .busy_o       (busy),
    .overrun_o    (overrun),
    .bound_err_o  (bound_err),
    .flag_clr_i   (flag_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected words as the design delivers them
  always @(negedge clk) begin
    if (rst_n && instr_valid) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected word", {16'h0, instr}, 32'hDEAD_BEEF);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk((e == 16'h0000) ? "R4 halt word" : "R3 fetched word", {16'h0, instr}, {16'h0, e});
      end
    end
  end

  // driver: push expected stream, then fire the start strobe
  task automatic start_pass(input logic [7:0] loc, input int n, input bit halt);
    code_loc = loc;
    halt_on  = halt;
    halt_w   = 17'(loc) * 17'd512 + 17'(n - 1);
    for (int i = 0; i < n; i++) begin
      logic [16:0] w;
      w = 17'(loc) * 17'd512 + 17'(i);
      exp_q.push_back((halt && i == n - 1) ? 16'h0000 : {1'b1, w[14:0]});
    end
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    while ((busy || exp_q.size() != 0) && k < TMO) begin
      @(negedge clk);
      k++;
    end
    chk(tag, k < TMO, 1);
  endtask

  task automatic pulse_clr(input logic [1:0] v);
    flag_clr = v;
    @(negedge clk) flag_clr = '0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 req", fetch_req, 0);
    chk("R1 valid", instr_valid, 0);
    chk("R1 flags", {overrun, bound_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R5 base address and busy, short program
    start_pass(8'd3, 6, 1'b1);
    chk("R2 first address", fetch_addr, 18'd3072);
    chk("R5 busy in pass", busy, 1);
    wait_idle("R4 pass 1 ends");
    chk("R5 busy after halt", busy, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        seen += fetch_req;
      end
      chk("R4 no fetch after halt", seen, 0);
    end

    // R4 immediate HALT
    start_pass(8'h40, 1, 1'b1);
    chk("R2 first address b40", fetch_addr, 18'h10000);
    wait_idle("R4 immediate halt");

    // R3 stalled grants, R2 base change mid-pass ignored
    gnt_slow = 1'b1;
    start_pass(8'd5, 10, 1'b1);
    repeat (2) @(negedge clk);
    chk("R3 addr held while stalled", fetch_addr[17:10], 8'd5);
    code_loc = 8'd77;
    wait_idle("R2 pass with base change");
    gnt_slow = 1'b0;
    chk("R6 no overrun yet", overrun, 0);

    // R6 late frame end sets overrun, pass continues
    start_pass(8'd7, 30, 1'b1);
    repeat (5) @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk) frame_end = 1'b0;
    chk("R6 overrun set", overrun, 1);
    chk("R6 pass continues", busy, 1);
    wait_idle("R6 pass completes");
    pulse_clr(2'b01);
    chk("R10 overrun cleared", overrun, 0);

    // R6 frame end while idle
    frame_end = 1'b1;
    @(negedge clk) frame_end = 1'b0;
    chk("R6 idle frame end ignored", overrun, 0);

    // R10 set and clear in same cycle
    start_pass(8'd2, 30, 1'b1);
    repeat (3) @(negedge clk);
    frame_end = 1'b1;
    flag_clr  = 2'b01;
    @(negedge clk);
    frame_end = 1'b0;
    flag_clr  = '0;
    chk("R10 set wins over clear", overrun, 1);
    wait_idle("R10 pass completes");
    pulse_clr(2'b01);

    // R7 start strobe mid-pass restarts from new base
    gnt_on = 1'b0;
    code_loc = 8'd9;
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    repeat (3) @(negedge clk);
    start_pass(8'd12, 6, 1'b1);
    chk("R7 overrun on abort", overrun, 1);
    chk("R7 restart address", fetch_addr, 18'd12288);
    gnt_on = 1'b1;
    wait_idle("R7 restarted pass");
    pulse_clr(2'b01);

    // R8 program region limit
    start_pass(8'd0, 4096, 1'b0);
    wait_idle("R8 full region");
    chk("R8 bound error", bound_err, 1);
    @(negedge clk);
    chk("R8 no fetch beyond", {busy, fetch_req}, 0);
    pulse_clr(2'b10);
    chk("R10 bound cleared", bound_err, 0);

    // R9 address space limit
    start_pass(8'd255, 512, 1'b0);
    wait_idle("R9 top block");
    @(negedge clk);
    chk("R9 bound error", bound_err, 1);
    chk("R9 no request", fetch_req, 0);
    chk("R9 overrun untouched", overrun, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule